// File: doc/BRIEF.md
# Alternating Index/Data Attribute Register Port

This block is a small attribute register file that a CPU reaches through a two-location bus window. One location takes every write, and an internal phase flip-flop decides what each write means. The first write after reset (or after a phase clear) loads an index. The write after that stores a byte into the register that the index selects. The writes then keep alternating between index and data.

Both locations can be read, and a read never moves the phase. A read of the first location returns the stored index. A read of the second location returns the register that the index currently selects. A separate clear input returns the phase to the index step. The system pulses this input when software reads a status register, so a driver can always reach a known phase. The contents of all registers are available at all times on a flat output bus for display logic.

The width of the index field sets the depth of the bank: 5 index bits give 32 registers. The index register keeps one bit more than the field. That extra bit reads back but takes no part in register selection.

Top module: `attr_port_regfile`

## Requirements
- R1: After the active-low reset, the index and every register are zero, the phase is the index step, and the read data output is zero.
- R2: A write to location 0 (`cpu_sel`=0) in the index step loads the index. A write to location 0 in the data step stores `cpu_wdata` into the register the index selects. Each such write flips the phase.
- R3: A read strobe to location 0 places the index on `cpu_rdata` one cycle later, zero-extended from bits [5:0]. `cpu_rdata` holds its value in cycles with no read strobe.
- R4: A read strobe to location 1 places, one cycle later, the register selected by index bits [4:0]. Index bit 5 has no effect on which register is selected.
- R5: Reads of either location leave the phase unchanged.
- R6: A pulse on `phase_clr` puts the phase in the index step for the next write. A write in the same cycle as the pulse still acts under the phase it found.
- R7: Writes to location 1 change no register, no index and no phase.
- R8: Register k appears on `attr_flat` bits [8k+7:8k], starting the cycle after the data write that stores it. All other registers keep their values.
- R9: Index bits [7:6] of a written byte are discarded and read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Location select: 0 = index/data location, 1 = selected-register location |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| phase_clr | input | 1 | Forces the next location-0 write to be an index write |
| attr_flat | output | 256 | All registers, register k at bits [8k+7:8k] |

## Verification
The main write function is tried with several write patterns. Plain alternating index/data pairs, including the first and last register, confirm the alternation. Writes that carry index bits 5 to 7 tell the stored index apart from the selecting field. Interleaved reads of both locations placed between an index write and its data write would expose any read that advances the phase. Clear pulses, alone and in the same cycle as a data write, tell a clear that acts after the write from one that cancels it. Location-1 writes in both phases, followed by a location-0 write, reveal whether they were ignored or advanced the phase.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;

   typedef enum logic {
      PH_INDEX = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;

endpackage

// File: rtl/ap_phase_ctl.sv
module ap_phase_ctl
   import attr_port_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_pri,
   input  logic   clr,
   output phase_e phase_q,
   output logic   idx_we,
   output logic   dat_we
);

   // decode against the phase seen at the edge; clear acts after the write
   always_comb begin
      idx_we = wr_pri && (phase_q == PH_INDEX);
      dat_we = wr_pri && (phase_q == PH_DATA);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_INDEX;
      end else if (clr) begin
         phase_q <= PH_INDEX;
      end else if (wr_pri) begin
         phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
      end
   end

endmodule

// File: rtl/ap_index_reg.sv
module ap_index_reg #(
   parameter int IDX_W = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [IDX_W:0] wdata,
   output logic [IDX_W:0] idx_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (we) begin
         idx_q <= wdata;
      end
   end

endmodule

// File: rtl/ap_reg_bank.sv
module ap_reg_bank #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 sel,
   input  logic [DATA_W-1:0]                wdata,
   output logic [(DATA_W<<IDX_W)-1:0]       flat
);

   localparam int NREG = 1 << IDX_W;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] q;

      assign hit = we && (sel == IDX_W'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            q <= wdata;
         end
      end

      assign flat[k*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/ap_read_mux.sv
module ap_read_mux #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter bit READ_REG = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd,
   input  logic                        sel,
   input  logic [IDX_W:0]              idx,
   input  logic [(DATA_W<<IDX_W)-1:0]  flat,
   output logic [DATA_W-1:0]           rdata
);

   logic [DATA_W-1:0] idx_ext;
   logic [DATA_W-1:0] reg_word;
   logic [DATA_W-1:0] mux_out;

   always_comb begin
      idx_ext            = '0;
      idx_ext[IDX_W:0]   = idx;
      reg_word           = flat[idx[IDX_W-1:0]*DATA_W +: DATA_W];
      mux_out            = sel ? reg_word : idx_ext;
   end

   if (READ_REG) begin : g_reg_rd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata <= '0;
         end else if (rd) begin
            rdata <= mux_out;
         end
      end
   end else begin : g_comb_rd
      assign rdata = mux_out;
   end

endmodule

// File: rtl/attr_port_regfile.sv
module attr_port_regfile
   import attr_port_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter bit READ_REG = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cpu_sel,
   input  logic                        cpu_wr,
   input  logic                        cpu_rd,
   input  logic [DATA_W-1:0]           cpu_wdata,
   output logic [DATA_W-1:0]           cpu_rdata,
   input  logic                        phase_clr,
   output logic [(DATA_W<<IDX_W)-1:0]  attr_flat
);

   localparam int NREG = 1 << IDX_W;

   if (DATA_W < IDX_W + 1) begin : g_bad_width
      $error("attr_port_regfile: DATA_W must hold the index plus its spare bit");
   end
   if (NREG < 2) begin : g_bad_depth
      $error("attr_port_regfile: IDX_W must be at least 1");
   end

   phase_e         phase_q;
   logic           idx_we;
   logic           dat_we;
   logic [IDX_W:0] idx_q;
   logic           wr_pri;

   assign wr_pri = cpu_wr && !cpu_sel;

   ap_phase_ctl u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_pri  (wr_pri),
      .clr     (phase_clr),
      .phase_q (phase_q),
      .idx_we  (idx_we),
      .dat_we  (dat_we)
   );

   ap_index_reg #(.IDX_W(IDX_W)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (idx_we),
      .wdata (cpu_wdata[IDX_W:0]),
      .idx_q (idx_q)
   );

   ap_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dat_we),
      .sel   (idx_q[IDX_W-1:0]),
      .wdata (cpu_wdata),
      .flat  (attr_flat)
   );

   ap_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .READ_REG(READ_REG)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (cpu_rd),
      .sel   (cpu_sel),
      .idx   (idx_q),
      .flat  (attr_flat),
      .rdata (cpu_rdata)
   );

endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        cpu_sel,
   input logic                        cpu_wr,
   input logic                        cpu_rd,
   input logic                        phase_clr,
   input logic [DATA_W-1:0]           cpu_rdata,
   input logic [(DATA_W<<IDX_W)-1:0]  attr_flat,
   input logic                        phase
);

   // R2
   pri_write_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_sel && !phase_clr) |=> (phase != $past(phase)));

   // R5
   read_keeps_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_wr && !phase_clr) |=> $stable(phase));

   // R6
   clr_to_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_clr |=> (phase == 1'b0));

   // R7
   sec_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_sel && !phase_clr) |=> ($stable(phase) && $stable(attr_flat)));

   // R8
   bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && !cpu_sel && phase) |=> $stable(attr_flat));

   // R9
   if (DATA_W > IDX_W + 1) begin : g_hi
      idx_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cpu_rd && !cpu_sel) |=> (cpu_rdata[DATA_W-1:IDX_W+1] == '0));
   end

endmodule

bind attr_port_regfile attr_port_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_sel   (cpu_sel),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .phase_clr (phase_clr),
   .cpu_rdata (cpu_rdata),
   .attr_flat (attr_flat),
   .phase     (phase_q)
);

// File: tb/test_attr_port_regfile.sv
module test_attr_port_regfile;

   localparam int DW   = 8;
   localparam int IW   = 5;
   localparam int NREG = 1 << IW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_sel = 1'b0;
   logic              cpu_wr = 1'b0;
   logic              cpu_rd = 1'b0;
   logic [DW-1:0]     cpu_wdata = '0;
   logic [DW-1:0]     cpu_rdata;
   logic              phase_clr = 1'b0;
   logic [DW*NREG-1:0] attr_flat;

   logic [DW-1:0] model [NREG];
   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   attr_port_regfile #(.DATA_W(DW), .IDX_W(IW)) i_attr_port_regfile (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_sel   (cpu_sel),
      .cpu_wr    (cpu_wr),
      .cpu_rd    (cpu_rd),
      .cpu_wdata (cpu_wdata),
      .cpu_rdata (cpu_rdata),
      .phase_clr (phase_clr),
      .attr_flat (attr_flat)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_bank(input string req);
      int bad = -1;
      for (int k = 0; k < NREG; k++)
         if (bad < 0 && attr_flat[k*DW +: DW] !== model[k]) bad = k;
      if (bad < 0) check(1'b1, req, 0, 0);
      else check(1'b0, $sformatf("%s reg %0d", req, bad),
                 32'(attr_flat[bad*DW +: DW]), 32'(model[bad]));
   endtask

   task automatic wr(input logic sel, input logic [DW-1:0] d, input logic clr = 1'b0);
      @(negedge clk);
      cpu_sel = sel; cpu_wdata = d; cpu_wr = 1'b1; phase_clr = clr;
      @(negedge clk);
      cpu_wr = 1'b0; phase_clr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [DW-1:0] d);
      @(negedge clk);
      cpu_sel = sel; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      d = cpu_rdata;
   endtask

   task automatic clr_pulse();
      @(negedge clk);
      phase_clr = 1'b1;
      @(negedge clk);
      phase_clr = 1'b0;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      check(cpu_rdata == 0, "R1 rdata", 32'(cpu_rdata), 0);
      check_bank("R1 bank");
      rd(1'b0, d);
      check(d == 0, "R1 index", 32'(d), 0);
   endtask

   task automatic t_alternate();
      logic [DW-1:0] d;
      wr(1'b0, 8'h03); wr(1'b0, 8'hA5); model[3] = 8'hA5;
      check_bank("R8 reg3");
      rd(1'b1, d);
      check(d == 8'hA5, "R4 sec read", 32'(d), 32'hA5);
      wr(1'b0, 8'h07); wr(1'b0, 8'h3C); model[7] = 8'h3C;
      check_bank("R2 second pair");
      wr(1'b0, 8'h1F); wr(1'b0, 8'hFF); model[31] = 8'hFF;
      wr(1'b0, 8'h00); wr(1'b0, 8'h81); model[0] = 8'h81;
      check_bank("R2 first and last reg");
   endtask

   task automatic t_index_bits();
      logic [DW-1:0] d, d2;
      wr(1'b0, 8'hE9);
      rd(1'b0, d);
      check(d == 8'h29, "R9 index readback", 32'(d), 32'h29);
      wr(1'b0, 8'h11); model[9] = 8'h11;
      check_bank("R4 bit5 ignored in select");
      rd(1'b1, d);
      check(d == 8'h11, "R4 sec read bit5 set", 32'(d), 32'h11);
      repeat (3) @(negedge clk);
      d2 = cpu_rdata;
      check(d2 == d, "R3 rdata hold", 32'(d2), 32'(d));
   endtask

   task automatic t_reads_no_toggle();
      logic [DW-1:0] d;
      wr(1'b0, 8'h04);
      rd(1'b0, d); rd(1'b1, d); rd(1'b0, d); rd(1'b1, d);
      wr(1'b0, 8'h77); model[4] = 8'h77;
      check_bank("R5 reads in data step");
      rd(1'b1, d); rd(1'b0, d);
      wr(1'b0, 8'h05);
      rd(1'b0, d);
      check(d == 8'h05, "R5 reads in index step", 32'(d), 32'h05);
      wr(1'b0, 8'h00); model[5] = 8'h00;
   endtask

   task automatic t_clear();
      logic [DW-1:0] d;
      wr(1'b0, 8'h06);
      clr_pulse();
      wr(1'b0, 8'h0A);
      rd(1'b0, d);
      check(d == 8'h0A, "R6 clear makes index write", 32'(d), 32'h0A);
      check_bank("R6 reg6 untouched");
      wr(1'b0, 8'h5E, 1'b1); model[10] = 8'h5E;
      check_bank("R6 write with clear stores data");
      wr(1'b0, 8'h03);
      rd(1'b0, d);
      check(d == 8'h03, "R6 next write is index", 32'(d), 32'h03);
      wr(1'b0, 8'h33); model[3] = 8'h33;
   endtask

   task automatic t_sec_write();
      logic [DW-1:0] d;
      wr(1'b0, 8'h08);
      wr(1'b1, 8'h99);
      check_bank("R7 sec write in data step");
      wr(1'b0, 8'h42); model[8] = 8'h42;
      check_bank("R7 phase not advanced");
      wr(1'b1, 8'h1C);
      wr(1'b0, 8'h0C);
      rd(1'b0, d);
      check(d == 8'h0C, "R7 sec write in index step", 32'(d), 32'h0C);
      check_bank("R7 bank final");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int k = 0; k < NREG; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_alternate();
      t_index_bits();
      t_reads_no_toggle();
      t_clear();
      t_sec_write();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule